// File: doc/BRIEF.md
# Single-Shot Down-Counting Timer with Live Count Correction

This block is a 16-bit one-shot timer. Software first loads a reload value. A shot then starts in one of two ways: software sets the run bit, or an external start line rises. When the shot starts, the counter loads the reload value and the pulse output inverts. After that the counter steps down once on every cycle in which the count-clock enable is high.

When the counter steps down past zero, the shot ends by itself:
- the run bit clears without any software action;
- the pulse output inverts again;
- an interrupt request pulses for one cycle.

Each shot therefore produces exactly one pulse on the output.

A correction register lets software lengthen a shot that is already running. A write to it adds the written value to the live count, so the pulse stretches by that many ticks. When no shot is running, a correction write only stores the value.

Registers are reached through a simple write port and a combinational read port. The 2-bit address selects one of four registers:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | control | write and read | bit 0 is the run bit |
| 1 | reload | write and read | value loaded at the start of a shot |
| 2 | correction | write and read | value added to a running count |
| 3 | counter | read only | live count |

Top module: `shot_timer`

## Requirements
- R1: After reset, pulse_out is 0, irq is 0 and the run bit (bit 0 of address 0) reads 0.
- R2: A write to address 0 with wr_data bit 0 set, while the timer is stopped, starts a shot. On the next edge the counter holds the reload value that was stored before that edge, the run bit reads 1, and pulse_out inverts.
- R3: A rising edge on ext_start starts a shot in the same way as R2. ext_start passes through two synchronizing flip-flops and an edge detector, so the run bit reads 1 after the third clock edge that samples the line high.
- R4: While running, the counter decrements by 1 on each edge where tick is 1. It holds its value when tick is 0 and no correction is written.
- R5: A tick while the counter is 0x0000 is an underflow. On that edge the counter becomes 0xFFFF, the run bit clears, and pulse_out inverts. On the following cycle irq is 1, and it is 1 for exactly that one cycle.
- R6: A write to address 2 while running adds wr_data to the counter. Any carry beyond 16 bits is dropped. For example, 0x5000 corrected by 0x4000 gives 0x9000.
- R7: A correction write on the same edge as a decrement (counter not 0) gives counter − 1 + correction.
- R8: A correction write while stopped updates only the value read at address 2. The counter read at address 3 is unchanged.
- R9: A start request (software or external) that arrives while a shot is running is ignored. The counter, run bit and pulse_out are unaffected.
- R10: A write to address 0 with bit 0 clear has no effect on the run bit, the counter or pulse_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 correction |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 correction, 3 counter |
| rd_data | output | 16 | Combinational read data |
| tick | input | 1 | Count-clock enable |
| ext_start | input | 1 | Asynchronous external start line, active on its rising edge |
| pulse_out | output | 1 | Flip-flop output, inverted at the start and at the end of each shot |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
Directed cases cover the following corner cases:
- the 0x5000 + 0x4000 correction, which separates an additive correction from a reload of the counter;
- a correction that overflows past 16 bits, which shows whether the carry is dropped;
- a correction on a tick cycle, which shows whether the decrement is lost or doubled;
- short shots of length 0 and 1, which expose off-by-one errors at underflow.

Start requests during a running shot, and writes of a cleared run bit, separate "ignored" from "restart" or "abort".

A constrained-random phase mixes several kinds of stimulus:
- sparse and dense tick patterns;
- random correction writes and start requests;
- external start pulses.

Every cycle of that phase is compared with a bench model, which covers the interleavings the directed cases do not reach.

// File: rtl/shot_timer.sv
module shot_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             tick,
  input  logic             ext_start,
  output logic             pulse_out,
  output logic             irq
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] cnt_q, reload_q, corr_q;
  logic             run_q, ff_q, irq_q;
  logic [2:0]       sync_q;

  logic sw_start, ext_edge, start_req, corr_wr, underflow;

  assign sw_start  = wr_en && wr_addr == 2'd0 && wr_data[0];
  assign ext_edge  = sync_q[1] && !sync_q[2];
  assign start_req = sw_start || ext_edge;
  assign corr_wr   = wr_en && wr_addr == 2'd2;
  assign underflow = run_q && tick && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_start};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      corr_q   <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd1) reload_q <= wr_data;
      if (corr_wr)                  corr_q   <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      ff_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!run_q) begin
        if (start_req) begin
          run_q <= 1'b1;
          cnt_q <= reload_q;
          ff_q  <= !ff_q;
        end
      end else if (underflow) begin
        run_q <= 1'b0;
        cnt_q <= ALL_ONES;
        ff_q  <= !ff_q;
        irq_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - WIDTH'(tick) + (corr_wr ? wr_data : '0);
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(WIDTH-1){1'b0}}, run_q};
      2'd1:    rd_data = reload_q;
      2'd2:    rd_data = corr_q;
      default: rd_data = cnt_q;
    endcase
  end

  assign pulse_out = ff_q;
  assign irq       = irq_q;

endmodule

module shot_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             pulse_out,
  input logic             irq,
  input logic             running,
  input logic [WIDTH-1:0] cnt
);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_end_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!running && cnt == '1));

  p_start_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> pulse_out != $past(pulse_out));

  p_stop_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (irq && pulse_out != $past(pulse_out)));

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !(wr_en && wr_addr == 2'd2)) |=> $stable(cnt));

  p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (running || $stable(cnt)));

  p_ff_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(tick && cnt == '0)) |=> (running && $stable(pulse_out)));

endmodule

bind shot_timer shot_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .pulse_out(pulse_out), .irq(irq), .running(run_q), .cnt(cnt_q)
);

// File: tb/test_shot_timer.sv
`timescale 1ns/1ps
module test_shot_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick = 1'b0;
  logic        ext_start = 1'b0;
  logic        pulse_out, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  shot_timer i_shot_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick),
    .ext_start(ext_start), .pulse_out(pulse_out), .irq(irq)
  );

  always #10 clk = ~clk;

  // bench model, built from the requirements
  logic [15:0] m_cnt, m_reload, m_corr;
  logic        m_run, m_ff, m_irq, m_valid;
  logic [2:0]  m_sync;

  function automatic logic [15:0] run_next(input logic [15:0] c, input logic tk,
                                           input logic cw, input logic [15:0] cv);
    logic [15:0] r;
    r = c;
    if (tk) r = r - 16'd1;
    if (cw) r = r + cv;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_reload <= '0; m_corr <= '0;
      m_run <= 0; m_ff <= 0; m_irq <= 0; m_valid <= 0; m_sync <= '0;
    end else begin
      logic st, cw;
      st = (wr_en && wr_addr == 2'd0 && wr_data[0]) || (m_sync[1] && !m_sync[2]);
      cw = wr_en && wr_addr == 2'd2;
      m_sync <= {m_sync[1:0], ext_start};
      if (wr_en && wr_addr == 2'd1) m_reload <= wr_data;
      if (cw) m_corr <= wr_data;
      m_irq <= 0;
      if (!m_run) begin
        if (st) begin m_run <= 1; m_cnt <= m_reload; m_ff <= !m_ff; m_valid <= 1; end
      end else if (tick && m_cnt == 16'h0000) begin
        m_run <= 0; m_cnt <= 16'hFFFF; m_ff <= !m_ff; m_irq <= 1;
      end else begin
        m_cnt <= run_next(m_cnt, tick, cw, wr_data);
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    rd_addr = 2'd0; #1;
    check(rd_data[0] == m_run, tag, rd_data, {15'd0, m_run});
    rd_addr = 2'd2; #1;
    check(rd_data == m_corr, tag, rd_data, m_corr);
    if (m_valid) begin
      rd_addr = 2'd3; #1;
      check(rd_data == m_cnt, tag, rd_data, m_cnt);
    end
    check(pulse_out == m_ff, tag, {15'd0, pulse_out}, {15'd0, m_ff});
    check(irq == m_irq, tag, {15'd0, irq}, {15'd0, m_irq});
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic tk, input string tag);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk); @(negedge clk);
    wr_en = 0; tick = 0;
    compare_all(tag);
  endtask

  task automatic read_cnt(input logic [15:0] exp, input string tag);
    rd_addr = 2'd3; #1;
    check(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic print_summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      print_summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse_out == 0 && irq == 0, "R1", {14'd0, pulse_out, irq}, 16'd0);
    rd_addr = 2'd0; #1;
    check(rd_data == 16'd0, "R1", rd_data, 16'd0);

    // R8: correction while stopped, then R2 start
    cyc(1, 2'd1, 16'h5000, 0, "R2");
    cyc(1, 2'd2, 16'h1234, 0, "R8");
    cyc(1, 2'd0, 16'h0001, 0, "R2");
    read_cnt(16'h5000, "R2");
    check(pulse_out == 1, "R2", {15'd0, pulse_out}, 16'd1);
    // R6: example 0x5000 + 0x4000
    cyc(1, 2'd2, 16'h4000, 0, "R6");
    read_cnt(16'h9000, "R6");
    // R7: correction with tick
    cyc(1, 2'd2, 16'h0010, 1, "R7");
    read_cnt(16'h900F, "R7");
    // R6: carry dropped
    cyc(1, 2'd2, 16'h8000, 0, "R6");
    read_cnt(16'h100F, "R6");
    // R4: hold without tick, step with tick
    cyc(0, 2'd0, 16'h0, 0, "R4");
    read_cnt(16'h100F, "R4");
    cyc(0, 2'd0, 16'h0, 1, "R4");
    read_cnt(16'h100E, "R4");
    // R9: restart ignored, R10: clear ignored
    cyc(1, 2'd1, 16'h0002, 0, "R9");
    cyc(1, 2'd0, 16'h0001, 0, "R9");
    read_cnt(16'h100E, "R9");
    cyc(1, 2'd0, 16'h0000, 0, "R10");
    read_cnt(16'h100E, "R10");
    check(pulse_out == 1, "R10", {15'd0, pulse_out}, 16'd1);
    // shrink shot: correct by 0xEFF2 -> 0x0000
    cyc(1, 2'd2, 16'hEFF2, 0, "R6");
    read_cnt(16'h0000, "R6");
    // R5: underflow
    cyc(0, 2'd0, 16'h0, 1, "R5");
    read_cnt(16'hFFFF, "R5");
    check(pulse_out == 0 && irq == 1, "R5", {14'd0, pulse_out, irq}, 16'd1);
    cyc(0, 2'd0, 16'h0, 1, "R5");
    check(irq == 0, "R5", {15'd0, irq}, 16'd0);
    read_cnt(16'hFFFF, "R5");
    // R8: correction while stopped leaves counter
    cyc(1, 2'd2, 16'h0077, 1, "R8");
    read_cnt(16'hFFFF, "R8");
    // R3: external start (reload now 2)
    ext_start = 1;
    cyc(0, 2'd0, 16'h0, 0, "R3");
    cyc(0, 2'd0, 16'h0, 0, "R3");
    rd_addr = 2'd0; #1;
    check(rd_data[0] == 0, "R3", rd_data, 16'd0);
    cyc(0, 2'd0, 16'h0, 0, "R3");
    rd_addr = 2'd0; #1;
    check(rd_data[0] == 1, "R3", rd_data, 16'd1);
    read_cnt(16'h0002, "R3");
    ext_start = 0;
    // shot of 3 ticks ends
    for (int i = 0; i < 3; i++) cyc(0, 2'd0, 16'h0, 1, "R5");
    check(irq == 1, "R5", {15'd0, irq}, 16'd1);
    // zero-length shot
    cyc(1, 2'd1, 16'h0000, 0, "R2");
    cyc(1, 2'd0, 16'h0001, 0, "R2");
    cyc(0, 2'd0, 16'h0, 1, "R5");
    check(irq == 1, "R5", {15'd0, irq}, 16'd1);

    // constrained random phase
    void'($urandom(32'd2024));
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic tk;
      r  = $urandom % 100;
      tk = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) ext_start = !ext_start;
      if (r < 6)       cyc(1, 2'd2, ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 64), tk, "R6");
      else if (r < 10) cyc(1, 2'd1, 16'($urandom % 200), tk, "R4");
      else if (r < 14) cyc(1, 2'd0, 16'($urandom % 2), tk, "R9");
      else             cyc(0, 2'd0, 16'h0, tk, "R4");
    end

    print_summary();
    $finish;
  end

endmodule